// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block turns a 32-bit avionics data word into a bipolar return-to-zero serial stream. The line is modelled as two digital drive outputs: `lineHi` pulses for a one and `lineLo` pulses for a zero. Each pulse lasts the first half of its bit period, and the line is null for the second half. The word is sent least significant bit first, so input bit 0 carries word bit 1 and input bit 31 carries word bit 32, which is sent last.

The last bit can be replaced by a parity bit computed over the first 31 bits. The parity is odd by default and even when the invert control is set. The bit period is the master clock divided by one of two ratios. After each word the line stays null for four bit periods before `busy` drops and a new word can be loaded. A self-test control steers the waveform onto a pair of loopback outputs instead of the line outputs, so receiver logic can be exercised without driving the bus.

Top module: `arinc_word_tx`

## Requirements
- R1: The word is sent least significant bit first: `wordIn[0]` is the first bit on the line and `wordIn[31]` is the last.
- R2: For a one, `lineHi` is 1 during the first half of the bit period (FAST_DIV/2 or SLOW_DIV/2 cycles). For a zero, `lineLo` is 1 during that half. Both are 0 during the second half, and they are never 1 together.
- R3: With `parityEn`=1 and `parityInvert`=0, bit 32 is sent so that the 32 sent bits hold an odd number of ones.
- R4: With `parityEn`=1 and `parityInvert`=1, bit 32 is sent so that the 32 sent bits hold an even number of ones.
- R5: With `parityEn`=0, bit 32 is sent exactly as `wordIn[31]`.
- R6: The bit period is FAST_DIV (10) master cycles when `slowRate`=0 and SLOW_DIV (80) when `slowRate`=1. `slowRate`, `parityEn` and `parityInvert` are captured when a word is loaded.
- R7: A `loadStrobe` sampled at a clock edge while `busy`=0 starts a word. `busy` and the first bit period begin in the cycle after that edge.
- R8: After bit 32, both outputs stay null for four bit periods with `busy` held at 1. `busy` is then 0, so a word occupies 36 bit periods.
- R9: A `loadStrobe` while `busy`=1 is ignored: the word in progress and its timing are unchanged.
- R10: With `selfTest`=1 the waveform appears on `loopHi`/`loopLo` and `lineHi`/`lineLo` stay 0. With `selfTest`=0 the loopback outputs stay 0.
- R11: While reset is active and after it, with no word in progress, `busy` and all four drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStrobe | input | 1 | Start a word when idle |
| wordIn | input | 32 | Word to send, bit 0 sent first |
| parityEn | input | 1 | Replace bit 32 by parity |
| parityInvert | input | 1 | 0 = odd parity, 1 = even parity |
| slowRate | input | 1 | 0 = bit period of FAST_DIV cycles, 1 = SLOW_DIV cycles |
| selfTest | input | 1 | Route the waveform to the loopback outputs |
| lineHi | output | 1 | Line drive for ones |
| lineLo | output | 1 | Line drive for zeros |
| busy | output | 1 | Word or inter-word gap in progress |
| loopHi | output | 1 | Loopback copy of the ones drive |
| loopLo | output | 1 | Loopback copy of the zeros drive |

## Verification
The bench builds the block with its default ratios of 10 and 80, so both the fast and the slow bit period are run cycle by cycle, with the half-period boundaries at 5 and 40. The four-bit-period gap spans 40 or 320 cycles, short enough that the bench can check every cycle of each word, including the exact cycle in which `busy` falls. The slow ratio being eight times the fast one shows that the rate captured at load is the one that governs the whole word.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
  typedef struct packed {
    logic loadWord;
    logic shiftBit;
    logic driveHalf;
  } txStrobes_t;
endpackage

// File: rtl/arinc_tx_ctrl.sv
module arinc_tx_ctrl
  import arinc_tx_pkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int WORD_BITS = 32,
  parameter int GAP_BITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStrobe,
  input  logic       slowRate,
  output txStrobes_t strobes,
  output logic       busy
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W = $clog2(MAX_DIV);
  localparam int MAX_BITS = (WORD_BITS > GAP_BITS) ? WORD_BITS : GAP_BITS;
  localparam int BIT_W = $clog2(MAX_BITS);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} txState_t;

  txState_t state;
  logic [CNT_W-1:0] cycCnt;
  logic [BIT_W-1:0] bitCnt;
  logic rateSlowQ;
  logic [CNT_W-1:0] lastCyc;
  logic [CNT_W-1:0] halfCyc;
  logic periodEnd;

  always_comb begin
    lastCyc = rateSlowQ ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
    halfCyc = rateSlowQ ? CNT_W'(SLOW_DIV / 2) : CNT_W'(FAST_DIV / 2);
    periodEnd = (cycCnt == lastCyc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cycCnt <= '0;
      bitCnt <= '0;
      rateSlowQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (loadStrobe) begin
            state <= ST_SEND;
            cycCnt <= '0;
            bitCnt <= '0;
            rateSlowQ <= slowRate;
          end
        end
        ST_SEND: begin
          if (periodEnd) begin
            cycCnt <= '0;
            if (bitCnt == BIT_W'(WORD_BITS - 1)) begin
              state <= ST_GAP;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (periodEnd) begin
            cycCnt <= '0;
            if (bitCnt == BIT_W'(GAP_BITS - 1)) begin
              state <= ST_IDLE;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadWord = (state == ST_IDLE) && loadStrobe;
    strobes.shiftBit = (state == ST_SEND) && periodEnd;
    strobes.driveHalf = (state == ST_SEND) && (cycCnt < halfCyc);
    busy = (state != ST_IDLE);
  end
endmodule

// File: rtl/arinc_tx_data.sv
module arinc_tx_data
  import arinc_tx_pkg::*;
#(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strobes,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic                 parityEn,
  input  logic                 parityInvert,
  output logic                 txHi,
  output logic                 txLo
);
  localparam int LAST = WORD_BITS - 1;

  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] loadValue;
  logic parityBit;

  always_comb begin
    // odd parity: last bit set when the leading bits hold an even count of ones
    parityBit = (~^wordIn[LAST-1:0]) ^ parityInvert;
    loadValue = wordIn;
    if (parityEn) loadValue[LAST] = parityBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.loadWord) begin
      shiftReg <= loadValue;
    end else if (strobes.shiftBit) begin
      shiftReg <= {1'b0, shiftReg[LAST:1]};
    end
  end

  always_comb begin
    txHi = strobes.driveHalf && shiftReg[0];
    txLo = strobes.driveHalf && !shiftReg[0];
  end
endmodule

// File: rtl/arinc_word_tx.sv
module arinc_word_tx
  import arinc_tx_pkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int WORD_BITS = 32,
  parameter int GAP_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadStrobe,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic                 parityEn,
  input  logic                 parityInvert,
  input  logic                 slowRate,
  input  logic                 selfTest,
  output logic                 lineHi,
  output logic                 lineLo,
  output logic                 busy,
  output logic                 loopHi,
  output logic                 loopLo
);
  txStrobes_t strobes;
  logic txHi;
  logic txLo;

  arinc_tx_ctrl #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV),
    .WORD_BITS(WORD_BITS), .GAP_BITS(GAP_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe),
    .slowRate(slowRate), .strobes(strobes), .busy(busy)
  );

  arinc_tx_data #(.WORD_BITS(WORD_BITS)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordIn(wordIn),
    .parityEn(parityEn), .parityInvert(parityInvert),
    .txHi(txHi), .txLo(txLo)
  );

  always_comb begin
    lineHi = txHi && !selfTest;
    lineLo = txLo && !selfTest;
    loopHi = txHi && selfTest;
    loopLo = txLo && selfTest;
  end
endmodule

// File: rtl/arinc_word_tx_checker.sv
module arinc_word_tx_checker #(
  parameter int FAST_DIV = 10,
  parameter int GAP_BITS = 4
) (
  input logic clk,
  input logic rstN,
  input logic loadStrobe,
  input logic selfTest,
  input logic lineHi,
  input logic lineLo,
  input logic busy,
  input logic loopHi,
  input logic loopLo
);
  localparam int MIN_GAP = GAP_BITS * FAST_DIV - 1;

  logic [15:0] nullRun;
  logic allNull;
  assign allNull = !lineHi && !lineLo && !loopHi && !loopLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nullRun <= '0;
    else if (busy && allNull) nullRun <= (nullRun == 16'hFFFF) ? nullRun : nullRun + 1'b1;
    else nullRun <= '0;
  end

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lineHi, lineLo, loopHi, loopLo}));
  assert_idle_null_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> allNull);
  assert_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(loadStrobe));
  assert_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (nullRun >= 16'(MIN_GAP)));
  assert_line_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    selfTest |-> (!lineHi && !lineLo));
  assert_loop_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !selfTest |-> (!loopHi && !loopLo));
endmodule

bind arinc_word_tx arinc_word_tx_checker #(.FAST_DIV(FAST_DIV), .GAP_BITS(GAP_BITS)) u_checker (
  .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .selfTest(selfTest),
  .lineHi(lineHi), .lineLo(lineLo), .busy(busy), .loopHi(loopHi), .loopLo(loopLo)
);

// File: tb/test_arinc_word_tx.sv
module test_arinc_word_tx;
  localparam int FAST = 10;
  localparam int SLOW = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadStrobe = 1'b0;
  logic [31:0] wordIn = '0;
  logic parityEn = 1'b0;
  logic parityInvert = 1'b0;
  logic slowRate = 1'b0;
  logic selfTest = 1'b0;
  logic lineHi, lineLo, busy, loopHi, loopLo;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  arinc_word_tx i_arinc_word_tx (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .wordIn(wordIn),
    .parityEn(parityEn), .parityInvert(parityInvert), .slowRate(slowRate),
    .selfTest(selfTest), .lineHi(lineHi), .lineLo(lineLo), .busy(busy),
    .loopHi(loopHi), .loopLo(loopLo)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not complete, act=%0d exp<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Expected sent word per R1/R3/R4/R5
  function automatic logic [31:0] sentWord(logic [31:0] w, logic pe, logic pi);
    logic [31:0] r = w;
    if (pe) r[31] = (~^w[30:0]) ^ pi;
    return r;
  endfunction

  // Sends one word and checks every cycle of its 36 bit periods (R2, R6, R7, R8)
  task automatic sendWord(input logic [31:0] w, input logic pe, input logic pi,
                          input logic slow, input logic st, input logic inject, input string tag);
    int div = slow ? SLOW : FAST;
    logic [31:0] ex = sentWord(w, pe, pi);
    int wordErr = 0;
    int first = fails;
    @(negedge clk);
    wordIn = w; parityEn = pe; parityInvert = pi; slowRate = slow; selfTest = st;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    // change controls after load: they must have been captured (R6)
    parityEn = ~pe; parityInvert = ~pi; slowRate = ~slow; wordIn = ~w;
    for (int k = 0; k <= 36 * div; k++) begin
      bit inSend = (k < 32 * div);
      bit firstHalf = ((k % div) < (div / 2));
      bit b = inSend ? ex[k / div] : 1'b0;
      logic eHi = inSend && firstHalf && b;
      logic eLo = inSend && firstHalf && !b;
      logic eBusy = (k < 36 * div);
      logic [4:0] act = {busy, lineHi, lineLo, loopHi, loopLo};
      logic [4:0] exv = {eBusy, st ? 2'b00 : {eHi, eLo}, st ? {eHi, eLo} : 2'b00};
      if (act != exv) begin
        wordErr++;
        if (wordErr <= 3) check(1'b0, tag, {27'd0, act}, {27'd0, exv});
      end
      if (k == 0) check(busy === 1'b1, "R7", {31'd0, busy}, 32'd1);
      if (k == 36 * div) check(busy === 1'b0, "R8", {31'd0, busy}, 32'd0);
      // R9: a load strobe mid-word must be ignored
      if (inject && k == 5 * div) loadStrobe = 1'b1;
      if (inject && k == 5 * div + 1) loadStrobe = 1'b0;
      @(negedge clk);
    end
    if (fails == first) check(wordErr == 0, tag, wordErr, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    // R11: outputs null and idle during reset
    check({busy, lineHi, lineLo, loopHi, loopLo} == 5'b0, "R11", {27'd0, busy, lineHi, lineLo, loopHi, loopLo}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, lineHi, lineLo, loopHi, loopLo} == 5'b0, "R11", {27'd0, busy, lineHi, lineLo, loopHi, loopLo}, 0);

    // R1: single-bit patterns at each end of the word
    sendWord(32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    sendWord(32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R3: all-zero leading bits give bit32=1 under odd parity
    sendWord(32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    // R4: even parity on all-ones leading bits gives bit32=1
    sendWord(32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    // R5: bit32 passes through with parity off
    sendWord(32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    // R6: slow rate
    sendWord(32'hA5C3_0F96, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    // R9: load while busy ignored
    sendWord(32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    // R10: self-test routing, fast and slow
    sendWord(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
    sendWord(32'h0F0F_F0F0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R10");
    // R2: random words under random controls
    for (int i = 0; i < 24; i++) begin
      logic [31:0] w = $urandom;
      logic pe = 1'($urandom);
      logic pi = 1'($urandom);
      logic sl = (i % 8 == 7);
      logic st = 1'($urandom);
      sendWord(w, pe, pi, sl, st, 1'($urandom), pe ? (pi ? "R4" : "R3") : "R2");
    end

    // R11: idle after the last word
    repeat (3) @(negedge clk);
    check({busy, lineHi, lineLo, loopHi, loopLo} == 5'b0, "R11", {27'd0, busy, lineHi, lineLo, loopHi, loopLo}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule